// File: doc/BRIEF.md
# Mode-0 SPI Master Transfer Sequencer

This block runs one byte-wide SPI transfer as the master, with the serial clock resting low and data sampled by the peripheral on the rising clock edge. A single write strobe both latches the outgoing byte and starts the transfer. The most significant bit goes out on the data line at once, and the serial clock is generated internally from a phase counter. The counter walks an idle state and sixteen half-bit states, so the serial clock runs at no more than half the system clock.

Each rising serial edge captures the incoming line into a receive register, building the received byte MSB first. Each falling edge moves the outgoing register on to its next bit. After the sixteenth half period the block raises a one-cycle completion pulse, drops busy and leaves the received byte on its output. Every half period lasts a programmable number of system clocks. Writes that arrive while a transfer is running are ignored.

Top module: `spi_mode0_sequencer`

## Requirements
- R1: A synchronous active-high reset leaves sclk low, busy low and done low.
- R2: sclk is low in every cycle in which busy is low.
- R3: A write strobe while busy is low loads wrData. From the next cycle busy is high and mosi carries wrData[7].
- R4: Each half period lasts HALF_CYC system clocks. sclk first rises HALF_CYC cycles after the load, and it gives exactly 8 rising edges per transfer.
- R5: mosi holds each bit for one full sclk period. It moves to the next lower bit only in the cycle in which sclk falls, and bit 7-k is driven during the k-th sclk high phase (k = 0..7).
- R6: miso is sampled on each cycle in which sclk rises. After the transfer, rxData holds the eight sampled bits, the first sample in bit 7.
- R7: done is high for exactly one cycle, the cycle after the sixteenth half period ends, and busy is low in that cycle. The load strobe is 16*HALF_CYC cycles before done.
- R8: A write strobe while busy is high has no effect: the mosi stream, the sclk timing and the final rxData are those of the running transfer.
- R9: Reset asserted during a transfer returns the block to idle (sclk low, busy low, done low), and a following write starts a clean transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | Write strobe: load byte and start a transfer |
| wrData | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, low when idle |
| mosi | output | 1 | Serial data to the peripheral, MSB first |
| busy | output | 1 | High while a transfer is running |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | 8 | Received byte |

## Verification
The transfer runs with several unrelated byte pairs: all zeros against all ones, alternating patterns, and asymmetric values such as 0x80 and 0x01. These pairs separate a bit-order reversal from an off-by-one shift and catch a stuck line. A stray write in the middle of a transfer shows whether the data register is reloaded or the phase counter restarted. A reset mid-transfer followed by a fresh transfer shows whether any state survives the reset. Each pattern is compared cycle by cycle against a behavioural timeline of sclk, mosi, busy and done.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // take a new transmit byte
    logic sample;  // sclk is about to rise: capture miso
    logic shift;   // sclk is about to fall: present next bit
  } seqStrobes_t;
endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrStrobe,
  output seqStrobes_t strb,
  output logic        sclk,
  output logic        busy,
  output logic        done
);
  localparam int LAST  = 2 * DATA_W;
  localparam int PH_W  = $clog2(LAST + 1);
  localparam int DIV_W = $clog2(HALF_CYC + 1);

  logic [PH_W-1:0]  phase;   // 0 = idle, 1..LAST = active half periods
  logic [DIV_W-1:0] divCnt;
  logic             sclkQ;
  logic             doneQ;
  logic             tick;
  logic             active;

  assign active = (phase != '0);
  assign tick   = active && (divCnt == DIV_W'(HALF_CYC - 1));

  always_comb begin
    strb.load   = wrStrobe && !active;
    strb.sample = tick && !sclkQ;
    strb.shift  = tick && sclkQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      divCnt <= '0;
      sclkQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strb.load) begin
        phase  <= PH_W'(1);
        divCnt <= '0;
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          sclkQ  <= ~sclkQ;
          if (phase == PH_W'(LAST)) begin
            phase <= '0;
            doneQ <= 1'b1;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign sclk = sclkQ;
  assign busy = active;
  assign done = doneQ;

  // R2
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclkQ);

  // R4
  sclk_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclkQ));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R7
  done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> ($past(phase) == PH_W'(LAST)) && !active);

  // R8
  load_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> !active);
endmodule

// File: rtl/spi_seq_datapath.sv
module spi_seq_datapath
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  input  logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txQ;
  logic [DATA_W-1:0] rxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      txQ <= '0;
      rxQ <= '0;
    end else begin
      if (strb.load) begin
        txQ <= wrData;
      end else if (strb.shift) begin
        txQ <= {txQ[DATA_W-2:0], 1'b0};
      end
      if (strb.sample) begin
        rxQ <= {rxQ[DATA_W-2:0], miso};
      end
    end
  end

  assign mosi   = txQ[DATA_W-1];
  assign rxData = rxQ;

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.shift) |=> $stable(mosi));

  // R5
  shift_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shift |-> sclk);

  // R6
  sample_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    strb.sample |=> sclk);
endmodule

// File: rtl/spi_mode0_sequencer.sv
module spi_mode0_sequencer #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxData
);
  import spi_seq_pkg::*;

  seqStrobes_t strb;

  spi_seq_ctrl #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .strb(strb),
    .sclk(sclk), .busy(busy), .done(done)
  );

  spi_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxData(rxData)
  );
endmodule

// File: tb/spi_mode0_sequencer_tb.sv
`timescale 1ns/1ps
module spi_mode0_sequencer_tb;
  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, busy, done;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_mode0_sequencer #(.DATA_W(8), .HALF_CYC(H)) u_dut (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rxData(rxData)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // t counts clock edges after the load edge; compared on the falling clock edge
  task automatic runXfer(input logic [7:0] tx, input logic [7:0] pr, input bit midWrite);
    @(negedge clk);
    wrData   = tx;
    wrStrobe = 1'b1;
    miso     = pr[7];
    for (int t = 0; t <= 16*H + 1; t++) begin
      @(negedge clk);
      wrStrobe = 1'b0;
      if (t < 16*H) begin
        int half = t / H;
        check(t == 0 ? "R3" : "R4", "busy", busy, 1);
        check("R4", "sclk", sclk, half % 2);
        check(t == 0 ? "R3" : (midWrite ? "R8" : "R5"), "mosi", mosi, tx[7 - half/2]);
        check("R7", "done", done, 0);
        miso = pr[7 - half/2];
      end else if (t == 16*H) begin
        check("R7", "done", done, 1);
        check("R7", "busy", busy, 0);
        check("R2", "sclk", sclk, 0);
        check(midWrite ? "R8" : "R6", "rxData", rxData, pr);
      end else begin
        check("R7", "done low", done, 0);
        check("R2", "sclk idle", sclk, 0);
      end
      if (midWrite && t == 5) begin
        wrStrobe = 1'b1;
        wrData   = ~tx;
      end
    end
    wrStrobe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "sclk", sclk, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);

    runXfer(8'hA5, 8'h3C, 1'b0);
    runXfer(8'h00, 8'hFF, 1'b0);
    runXfer(8'hFF, 8'h00, 1'b0);
    runXfer(8'h80, 8'h01, 1'b0);
    runXfer(8'h55, 8'hAA, 1'b0);
    // R8 write during busy
    runXfer(8'h6B, 8'hD2, 1'b1);

    // R9 reset mid-transfer
    @(negedge clk);
    wrData = 8'hF0; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "busy", busy, 0);
    check("R9", "sclk", sclk, 0);
    check("R9", "done", done, 0);
    repeat (3) @(negedge clk);
    check("R9", "still idle", busy, 0);
    runXfer(8'h1E, 8'hC3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule